// File: doc/BRIEF.md
# PHY Link Status Poller

This block keeps a live view of an Ethernet PHY's link state without software involvement. It runs a fixed poll loop around an existing management-bus master. The master already serialises frames and exposes a simple request/busy/read-data handshake. At a programmable interval the poller asks the master to read the PHY's auxiliary status summary register. It waits for the transfer to finish and then decodes the returned word into a few flags for the rest of the chip. These are link up, autonegotiation complete, the three-bit speed/duplex code and a 100 Mb/s full-duplex indication.

A transfer can fail when nothing answers on the bus. The master reports this as a read failure. In that case the poller discards the data it returned, raises a no-response flag and reports the link as down until a later read succeeds. Whenever the link bit or the speed/duplex code differs from the previous successful poll, the poller emits a one-cycle change pulse. Downstream logic, such as a MAC rate selector or an interrupt collector, can react to that pulse.

Top module: `phy_status_poller`

## Requirements
- R1: While and directly after reset, `req_rd`, `link_up`, `an_done`, `speed_code`, `is_100fd`, `no_resp` and `status_chg` are all 0.
- R2: At the end of a poll, `req_rd` goes high at the (POLL_CYCLES+1)-th rising edge after the edge at which `mst_busy` is first sampled low, provided `mst_busy` stays low.
- R3: `req_rd` never rises when `mst_busy` was high at the preceding edge. If `mst_busy` is held high by another user after the interval expires, the request waits, and it rises at the first edge that samples `mst_busy` low.
- R4: Once raised, `req_rd` stays high until an edge samples `mst_busy` high, and it is low from that edge on.
- R5: While `req_rd` is high, `reg_sel` is 5'h19 and `dev_sel` equals the DEV_ADDR parameter.
- R6: After a successful read (`mst_rd_fail` low), `link_up` takes bit 2 of `mst_rdata`. Every status output updates at the second rising edge after `mst_busy` is first sampled low.
- R7: After a successful read, `an_done` takes bit 15 of `mst_rdata` (1 = autonegotiation finished, 0 = still running).
- R8: After a successful read, `speed_code` takes bits 10:8 of `mst_rdata`. `is_100fd` is 1 exactly when that code is 3'b101.
- R9: After a failed read (`mst_rd_fail` high), `no_resp` is 1 and `link_up` is 0, while `an_done`, `speed_code` and `is_100fd` keep their values. The next successful read clears `no_resp`.
- R10: `status_chg` is high for exactly one cycle, together with the update, when a successful read's link bit or speed code differs from the previous successful read (0 and 3'b000 after reset). It stays low after a failed read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mst_busy | input | 1 | Management master transfer in progress |
| mst_rdata | input | 16 | Word returned by the last read |
| mst_rd_fail | input | 1 | Last read got no answer from the PHY |
| req_rd | output | 1 | Read request to the master, rising edge significant |
| reg_sel | output | 5 | Register address presented with the request |
| dev_sel | output | 5 | PHY device address presented with the request |
| link_up | output | 1 | Link established (forced 0 while no_resp) |
| an_done | output | 1 | Autonegotiation complete |
| speed_code | output | 3 | Decoded speed/duplex field |
| is_100fd | output | 1 | Speed code means 100 Mb/s full duplex |
| no_resp | output | 1 | Last poll got no answer |
| status_chg | output | 1 | One-cycle pulse on link or speed change |

## Verification
The hardest situation to reach is another bus user holding `mst_busy` high just as the poll interval runs out. Only then does the request have to wait instead of firing on time. The stimulus raises busy between two polls and keeps it high for several intervals while it watches the request line. It then releases busy and expects the request one edge later. A second hard case is a failed read followed by a successful read that repeats the old link and speed values. That sequence shows whether the change pulse compares against the last good poll or against the forced-down link.

// File: rtl/phy_poll_pkg.sv
package phy_poll_pkg;

  localparam int unsigned STAT_DATA_W = 16;
  localparam logic [4:0]  STAT_REG_ADDR = 5'h19;
  localparam int unsigned LINK_POS = 2;
  localparam int unsigned AN_POS   = 15;
  localparam int unsigned SPD_LSB  = 8;
  localparam int unsigned SPD_W    = 3;
  localparam logic [SPD_W-1:0] SPD_100_FULL = 3'b101;

  typedef enum logic [1:0] {
    PS_WAIT = 2'd0,
    PS_REQ  = 2'd1,
    PS_HOLD = 2'd2,
    PS_TAKE = 2'd3
  } poll_st_t;

endpackage

// File: rtl/poll_rst_sync.sv
module poll_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ni = stage_q[1];
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int unsigned POLL_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int unsigned CNT_W = (POLL_CYCLES > 2) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (en && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import phy_poll_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic mst_busy,
  input  logic tmr_expired,
  output logic tmr_clr,
  output logic tmr_en,
  output logic req_rd,
  output logic take
);
  poll_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_WAIT: if (tmr_expired && !mst_busy) st_d = PS_REQ;
      PS_REQ:  if (mst_busy)                 st_d = PS_HOLD;
      PS_HOLD: if (!mst_busy)                st_d = PS_TAKE;
      PS_TAKE:                               st_d = PS_WAIT;
      default:                               st_d = PS_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= PS_WAIT;
    else         st_q <= st_d;
  end

  assign req_rd  = (st_q == PS_REQ);
  assign take    = (st_q == PS_TAKE);
  assign tmr_clr = (st_q != PS_WAIT);
  assign tmr_en  = (st_q == PS_WAIT);

  // R4: request released at the edge after busy is seen
  assert_req_release_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_rd && mst_busy) |=> !req_rd);

  // R3: no new request launched over a busy bus
  assert_no_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(req_rd) |-> $past(!mst_busy));
endmodule

// File: rtl/poll_decode.sv
module poll_decode
  import phy_poll_pkg::*;
#(
  parameter int unsigned DATA_W = STAT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              take,
  input  logic              rd_fail,
  input  logic [DATA_W-1:0] rdata,
  output logic              link_up,
  output logic              an_done,
  output logic [SPD_W-1:0]  speed_code,
  output logic              is_100fd,
  output logic              no_resp,
  output logic              status_chg
);
  logic             link_q, link_d;
  logic             good_link_q, good_link_d;
  logic             an_q, an_d;
  logic [SPD_W-1:0] spd_q, spd_d;
  logic             nr_q, nr_d;
  logic             chg_q, chg_d;

  logic             new_link;
  logic [SPD_W-1:0] new_spd;
  logic             unused_rdata;

  assign new_link     = rdata[LINK_POS];
  assign new_spd      = rdata[SPD_LSB +: SPD_W];
  assign unused_rdata = ^rdata;

  always_comb begin
    link_d      = link_q;
    good_link_d = good_link_q;
    an_d        = an_q;
    spd_d       = spd_q;
    nr_d        = nr_q;
    chg_d       = 1'b0;
    if (take) begin
      if (rd_fail) begin
        nr_d   = 1'b1;
        link_d = 1'b0;
      end else begin
        nr_d        = 1'b0;
        link_d      = new_link;
        good_link_d = new_link;
        an_d        = rdata[AN_POS];
        spd_d       = new_spd;
        chg_d       = (new_link != good_link_q) || (new_spd != spd_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q      <= 1'b0;
      good_link_q <= 1'b0;
      an_q        <= 1'b0;
      spd_q       <= '0;
      nr_q        <= 1'b0;
      chg_q       <= 1'b0;
    end else begin
      link_q      <= link_d;
      good_link_q <= good_link_d;
      an_q        <= an_d;
      spd_q       <= spd_d;
      nr_q        <= nr_d;
      chg_q       <= chg_d;
    end
  end

  assign link_up    = link_q;
  assign an_done    = an_q;
  assign speed_code = spd_q;
  assign is_100fd   = (spd_q == SPD_100_FULL);
  assign no_resp    = nr_q;
  assign status_chg = chg_q;

  // R9: a failed read forces the link down and freezes the other fields
  assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (take && rd_fail) |=> (no_resp && !link_up && $stable(spd_q) && $stable(an_q)));

  // R9: link never reported up while the responder is missing
  assert_noresp_link_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    no_resp |-> !link_up);

  // R10: change indication lasts a single cycle
  assert_chg_single_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    status_chg |=> !status_chg);

  // R10: no change indication without a completed poll
  assert_chg_needs_take_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    status_chg |-> $past(take && !rd_fail));
endmodule

// File: rtl/phy_status_poller.sv
module phy_status_poller
  import phy_poll_pkg::*;
#(
  parameter int unsigned POLL_CYCLES = 1000,
  parameter logic [4:0]  DEV_ADDR    = 5'd1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mst_busy,
  input  logic [STAT_DATA_W-1:0] mst_rdata,
  input  logic                   mst_rd_fail,
  output logic                   req_rd,
  output logic [4:0]             reg_sel,
  output logic [4:0]             dev_sel,
  output logic                   link_up,
  output logic                   an_done,
  output logic [SPD_W-1:0]       speed_code,
  output logic                   is_100fd,
  output logic                   no_resp,
  output logic                   status_chg
);
  logic rst_ni;
  logic tmr_clr, tmr_en, tmr_expired, take;

  poll_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .clr     (tmr_clr),
    .en      (tmr_en),
    .expired (tmr_expired)
  );

  poll_seq u_seq (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .mst_busy    (mst_busy),
    .tmr_expired (tmr_expired),
    .tmr_clr     (tmr_clr),
    .tmr_en      (tmr_en),
    .req_rd      (req_rd),
    .take        (take)
  );

  poll_decode #(.DATA_W(STAT_DATA_W)) u_dec (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .take       (take),
    .rd_fail    (mst_rd_fail),
    .rdata      (mst_rdata),
    .link_up    (link_up),
    .an_done    (an_done),
    .speed_code (speed_code),
    .is_100fd   (is_100fd),
    .no_resp    (no_resp),
    .status_chg (status_chg)
  );

  assign reg_sel = STAT_REG_ADDR;
  assign dev_sel = DEV_ADDR;
endmodule

// File: tb/tb_phy_status_poller.sv
module tb_phy_status_poller;
  localparam int unsigned P   = 24;
  localparam logic [4:0]  DEV = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mst_busy;
  logic [15:0] mst_rdata;
  logic        mst_rd_fail;
  logic        req_rd;
  logic [4:0]  reg_sel, dev_sel;
  logic        link_up, an_done, is_100fd, no_resp, status_chg;
  logic [2:0]  speed_code;

  always #2 clk = ~clk;

  phy_status_poller #(.POLL_CYCLES(P), .DEV_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .mst_busy(mst_busy), .mst_rdata(mst_rdata),
    .mst_rd_fail(mst_rd_fail), .req_rd(req_rd), .reg_sel(reg_sel),
    .dev_sel(dev_sel), .link_up(link_up), .an_done(an_done),
    .speed_code(speed_code), .is_100fd(is_100fd), .no_resp(no_resp),
    .status_chg(status_chg)
  );

  typedef struct packed {
    logic       link;
    logic       an;
    logic [2:0] spd;
    logic       fd;
    logic       nr;
    logic       chg;
  } exp_t;

  exp_t exp_q[$];
  event done_ev;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   ended = 0;

  logic       m_an = 0, m_link = 0, m_nr = 0;
  logic [2:0] m_spd = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // driver: acts as the management master and pushes expected results
  task automatic do_poll(input logic [15:0] data, input logic fail, input int exp_gap);
    int   n = 0;
    exp_t e;
    logic chg;
    do begin
      @(posedge clk); #1; n++;
    end while (!req_rd);
    if (exp_gap >= 0) chk(n == exp_gap, "R2 request spacing", n, exp_gap);
    chk(reg_sel == 5'h19, "R5 register address", reg_sel, 5'h19);
    chk(dev_sel == DEV, "R5 device address", dev_sel, DEV);
    @(negedge clk);
    chk(req_rd == 1'b1, "R4 request held until busy", req_rd, 1);
    mst_busy = 1'b1;
    @(posedge clk); #1;
    chk(req_rd == 1'b0, "R4 request drop after busy", req_rd, 0);
    repeat (6) @(negedge clk);
    mst_rdata   = data;
    mst_rd_fail = fail;
    mst_busy    = 1'b0;
    if (fail) begin
      m_nr = 1; chg = 0;
      e = '{link:1'b0, an:m_an, spd:m_spd, fd:(m_spd == 3'b101), nr:1'b1, chg:1'b0};
    end else begin
      chg    = (data[2] != m_link) || (data[10:8] != m_spd);
      m_link = data[2]; m_an = data[15]; m_spd = data[10:8]; m_nr = 0;
      e = '{link:m_link, an:m_an, spd:m_spd, fd:(m_spd == 3'b101), nr:1'b0, chg:chg};
    end
    exp_q.push_back(e);
    -> done_ev;
  endtask

  // monitor: compares at the second edge after busy low
  initial begin
    forever begin
      exp_t e;
      @(done_ev);
      repeat (2) @(posedge clk);
      #1;
      e = exp_q.pop_front();
      chk(link_up == e.link, "R6/R9 link_up", link_up, e.link);
      chk(an_done == e.an, "R7/R9 an_done", an_done, e.an);
      chk(speed_code == e.spd, "R8/R9 speed_code", speed_code, e.spd);
      chk(is_100fd == e.fd, "R8 is_100fd", is_100fd, e.fd);
      chk(no_resp == e.nr, "R9 no_resp", no_resp, e.nr);
      chk(status_chg == e.chg, "R10 status_chg", status_chg, e.chg);
      @(posedge clk); #1;
      chk(status_chg == 1'b0, "R10 pulse width", status_chg, 0);
    end
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    wrap_up();
  end

  initial begin
    rst_n = 1'b0; mst_busy = 1'b0; mst_rdata = 16'h0; mst_rd_fail = 1'b0;
    repeat (4) @(negedge clk);
    chk(req_rd == 0 && link_up == 0 && an_done == 0 && no_resp == 0,
        "R1 reset outputs", {req_rd, link_up, an_done, no_resp}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(speed_code == 0 && is_100fd == 0 && status_chg == 0 && req_rd == 0,
        "R1 after release", {speed_code, is_100fd, status_chg, req_rd}, 0);

    do_poll(16'h8504, 1'b0, -1);      // link up, an done, 100FD: change
    do_poll(16'h8504, 1'b0, P + 2);   // identical: no change
    do_poll(16'h0000, 1'b1, P + 2);   // no responder
    do_poll(16'h8504, 1'b0, P + 2);   // recovers, same as last good: no change
    do_poll(16'h0104, 1'b0, P + 2);   // speed code 001, an running: change
    do_poll(16'h0100, 1'b0, P + 2);   // link drops: change
    do_poll(16'hFFFF, 1'b1, P + 2);   // failed read with noisy data
    do_poll(16'h0100, 1'b0, P + 2);   // same as last good: no change

    // R3: another user holds the bus across the interval
    repeat (4) @(negedge clk);
    mst_busy = 1'b1;
    for (int i = 0; i < 3 * P; i++) begin
      @(negedge clk);
      if (req_rd) chk(1'b0, "R3 request while busy", req_rd, 0);
    end
    chk(req_rd == 1'b0, "R3 request held off", req_rd, 0);
    mst_busy = 1'b0;
    do_poll(16'hFFFF, 1'b0, 1);       // fires at first edge seeing busy low
    repeat (6) @(negedge clk);
    wrap_up();
  end
endmodule